// File: doc/BRIEF.md
# Looping Pulse Train Sequencer

The block plays back a list of timed output levels held in a small memory that sits outside it. Each 16-bit entry gives one output level and a duration counted in ticks. On a start command the sequencer reads entries one at a time from address 0. It holds the output at each entry's level for that entry's duration, and it finishes a pass at an entry whose duration is zero or after the entry at the highest address. A single-shot run ends after one pass. A repeating run begins again at address 0 after every pass. When pass counting is switched on, a repeating run stops once a programmed number of passes has completed.

Three one-cycle event pulses report progress: run finished, entry threshold reached, and pass limit reached. A stop command stops the run at the next tick. When no run is active, the output line and its enable follow two configuration inputs. The memory port has a fixed one-cycle read latency. Data returned in the cycle after a read strobe is always consumed, so the port has no back-pressure and the memory never has to stall. Between entries the sequencer spends two clock cycles (read, then load), and the output keeps its previous level during them.

Top module: `pulse_seq_tx`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_rd` and all three event pulses are low.
- R2: A `start` pulse while idle makes `mem_rd` high with `mem_addr` = 0 in the next cycle. A `start` while busy is ignored and causes no extra reads.
- R3: An entry holds the level in bit 15 and the duration in ticks in bits 14:0. While an entry plays, `tx_out` equals its level for exactly that many ticks, and `tx_oe` is 1 for the whole run.
- R4: A pass ends at an entry whose duration is zero, or when the entry at the highest address finishes, whichever comes first.
- R5: With `cont_mode` = 0, the end of a pass returns the block to idle, and `end_evt` is high for exactly one cycle, the first cycle in which the block is idle.
- R6: With `cont_mode` = 1 and `loop_cnt_en` = 0, every pass end restarts reading at address 0, and the run goes on until stopped.
- R7: With `cont_mode` = 1 and `loop_cnt_en` = 1, completed passes are counted from the start. When the count reaches `loop_limit`, `loop_evt` and `end_evt` pulse together and the block goes idle. A limit of 0 never ends the run.
- R8: A `loop_cnt_clr` pulse sets the completed-pass count to zero in the middle of a run.
- R9: `thr_evt` pulses once per run, in the cycle after the `entry_limit`-th entry of that run finishes. Entries are counted across passes. An `entry_limit` of 0 disables the pulse.
- R10: A `stop` request, held internally until it takes effect, ends the run at the first clock edge with `tick_en` = 1. The block then goes idle and raises no `end_evt`.
- R11: While idle, `tx_out` = `idle_level` and `tx_oe` = `idle_oe`.
- R12: Entry durations advance only on cycles with `tick_en` = 1. With `tick_en` held low, a playing entry holds its level indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Duration time base, one tick per high cycle |
| start | input | 1 | Begin a run from address 0 |
| stop | input | 1 | Stop request, applied at next tick |
| cont_mode | input | 1 | 1: repeat passes, 0: single pass |
| loop_cnt_en | input | 1 | Enable pass counting in repeat mode |
| loop_limit | input | LOOP_W | Number of passes that ends a counted run |
| loop_cnt_clr | input | 1 | Clear completed-pass count |
| entry_limit | input | ENT_W | Entry count that raises `thr_evt` (0 = off) |
| idle_level | input | 1 | Output level while idle |
| idle_oe | input | 1 | Output enable while idle |
| mem_rd | output | 1 | Read strobe to entry memory |
| mem_addr | output | ADDR_W | Read address |
| mem_rdata | input | 16 | Entry read, valid the cycle after `mem_rd` |
| tx_out | output | 1 | Output line |
| tx_oe | output | 1 | Output enable |
| busy | output | 1 | Run in progress |
| end_evt | output | 1 | Run finished pulse |
| thr_evt | output | 1 | Entry threshold pulse |
| loop_evt | output | 1 | Pass limit reached pulse |

## Verification
The hardest state to reach from the ports is a counted repeating run whose pass count is cleared part-way through. Here the end time depends on when the clear lands relative to the pass boundaries, and the entry threshold is crossed inside a later pass. The stimulus sets this up with a three-entry program of known durations, so that every pass boundary falls on a known cycle. It pulses the clear at a chosen cycle within the second pass, then checks that the end and loop pulses move out by exactly one pass length. A second hard case is a stop request issued while ticks are held off. The stimulus keeps `tick_en` low across the stop pulse and checks that the run is still alive until ticks resume.

// File: rtl/pulse_seq_pkg.sv
package pulse_seq_pkg;
  localparam int ENTRY_W = 16;
  localparam int DUR_W   = ENTRY_W - 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_LOAD  = 2'd2,
    ST_SEND  = 2'd3
  } seq_state_e;

  // level sits in the top bit, duration below it
  typedef struct packed {
    logic             level;
    logic [DUR_W-1:0] dur;
  } entry_t;
endpackage

// File: rtl/ps_dur_timer.sv
module ps_dur_timer #(
  parameter int DUR_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DUR_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [DUR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - DUR_W'(1);
    end
  end

  // last tick of the current entry
  assign expire = tick && (cnt_q == DUR_W'(1));
endmodule

// File: rtl/ps_loop_track.sv
module ps_loop_track #(
  parameter int LOOP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_clr,
  input  logic              cmd_clr,
  input  logic              pass_inc,
  input  logic              enable,
  input  logic [LOOP_W-1:0] limit,
  output logic              reached
);
  logic [LOOP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run_clr || cmd_clr) begin
      cnt_q <= '0;
    end else if (pass_inc && enable) begin
      cnt_q <= cnt_q + LOOP_W'(1);
    end
  end

  // true when the pass now ending is the final counted one
  assign reached = enable && (limit != '0) && ((cnt_q + LOOP_W'(1)) == limit);
endmodule

// File: rtl/ps_entry_track.sv
module ps_entry_track #(
  parameter int ENT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_clr,
  input  logic             entry_done,
  input  logic [ENT_W-1:0] limit,
  output logic             thr_pulse
);
  localparam logic [ENT_W-1:0] CNT_MAX = {ENT_W{1'b1}};

  logic [ENT_W-1:0] cnt_q;
  logic             hit;
  logic             thr_q;

  assign hit = entry_done && (limit != '0) && (cnt_q != CNT_MAX) &&
               ((cnt_q + ENT_W'(1)) == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      thr_q <= 1'b0;
    end else begin
      thr_q <= hit;
      if (run_clr) begin
        cnt_q <= '0;
      end else if (entry_done && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + ENT_W'(1);
      end
    end
  end

  assign thr_pulse = thr_q;
endmodule

// File: rtl/pulse_seq_tx.sv
module pulse_seq_tx
  import pulse_seq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LOOP_W = 10,
  parameter int ENT_W  = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                start,
  input  logic                stop,
  input  logic                cont_mode,
  input  logic                loop_cnt_en,
  input  logic [LOOP_W-1:0]   loop_limit,
  input  logic                loop_cnt_clr,
  input  logic [ENT_W-1:0]    entry_limit,
  input  logic                idle_level,
  input  logic                idle_oe,
  output logic                mem_rd,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic [ENTRY_W-1:0]  mem_rdata,
  output logic                tx_out,
  output logic                tx_oe,
  output logic                busy,
  output logic                end_evt,
  output logic                thr_evt,
  output logic                loop_evt
);
  localparam logic [ADDR_W-1:0] ADDR_LAST = {ADDR_W{1'b1}};

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              lvl_q, lvl_d;
  logic              stop_pend_q;
  logic              end_q, loop_q;

  entry_t ent;
  logic   active;
  logic   stop_now;
  logic   dur_done;
  logic   entry_done;
  logic   zero_end;
  logic   pass_done;
  logic   loop_hit;
  logic   finish;
  logic   run_start;
  logic   load_timer;

  assign ent       = entry_t'(mem_rdata);
  assign active    = (state_q != ST_IDLE);
  assign run_start = (state_q == ST_IDLE) && start;
  assign stop_now  = active && tick_en && (stop || stop_pend_q);

  assign entry_done = (state_q == ST_SEND) && dur_done && !stop_now;
  assign zero_end   = (state_q == ST_LOAD) && (ent.dur == '0) && !stop_now;
  assign pass_done  = zero_end || (entry_done && ptr_q == ADDR_LAST);
  assign finish     = pass_done && (!cont_mode || loop_hit);
  assign load_timer = (state_q == ST_LOAD) && (ent.dur != '0);

  ps_dur_timer #(.DUR_W(DUR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_timer),
    .load_val (ent.dur),
    .tick     (tick_en && state_q == ST_SEND),
    .expire   (dur_done)
  );

  ps_loop_track #(.LOOP_W(LOOP_W)) u_loops (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_clr  (run_start),
    .cmd_clr  (loop_cnt_clr),
    .pass_inc (pass_done && cont_mode),
    .enable   (loop_cnt_en),
    .limit    (loop_limit),
    .reached  (loop_hit)
  );

  ps_entry_track #(.ENT_W(ENT_W)) u_entries (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_clr    (run_start),
    .entry_done (entry_done),
    .limit      (entry_limit),
    .thr_pulse  (thr_evt)
  );

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    lvl_d   = lvl_q;
    if (stop_now) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_d = ST_FETCH;
            ptr_d   = '0;
            lvl_d   = idle_level;
          end
        end
        ST_FETCH: state_d = ST_LOAD;
        ST_LOAD: begin
          if (ent.dur == '0) begin
            state_d = finish ? ST_IDLE : ST_FETCH;
            ptr_d   = '0;
          end else begin
            state_d = ST_SEND;
            lvl_d   = ent.level;
          end
        end
        ST_SEND: begin
          if (dur_done) begin
            if (ptr_q == ADDR_LAST) begin
              state_d = finish ? ST_IDLE : ST_FETCH;
              ptr_d   = '0;
            end else begin
              state_d = ST_FETCH;
              ptr_d   = ptr_q + ADDR_W'(1);
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      ptr_q       <= '0;
      lvl_q       <= 1'b0;
      stop_pend_q <= 1'b0;
      end_q       <= 1'b0;
      loop_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      lvl_q   <= lvl_d;
      end_q   <= finish && !stop_now;
      loop_q  <= finish && cont_mode && loop_hit;
      if (state_d == ST_IDLE) begin
        stop_pend_q <= 1'b0;
      end else if (active && stop) begin
        stop_pend_q <= 1'b1;
      end
    end
  end

  assign mem_rd   = (state_q == ST_FETCH);
  assign mem_addr = ptr_q;
  assign busy     = active;
  assign tx_out   = active ? lvl_q : idle_level;
  assign tx_oe    = active ? 1'b1 : idle_oe;
  assign end_evt  = end_q;
  assign loop_evt = loop_q;
endmodule

// File: rtl/pulse_seq_tx_chk.sv
module pulse_seq_tx_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              stop,
  input logic              tick_en,
  input logic              cont_mode,
  input logic              loop_cnt_en,
  input logic              busy,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              end_evt,
  input logic              loop_evt
);
  assert_start_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (mem_rd && mem_addr == '0));

  assert_read_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  assert_end_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> !end_evt);

  assert_end_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |-> !busy);

  assert_loop_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    loop_evt |-> end_evt);

  assert_loop_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_evt) |-> $past(cont_mode && loop_cnt_en));

  assert_stop_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop && tick_en) |=> (!busy && !end_evt));
endmodule

bind pulse_seq_tx pulse_seq_tx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .stop        (stop),
  .tick_en     (tick_en),
  .cont_mode   (cont_mode),
  .loop_cnt_en (loop_cnt_en),
  .busy        (busy),
  .mem_rd      (mem_rd),
  .mem_addr    (mem_addr),
  .end_evt     (end_evt),
  .loop_evt    (loop_evt)
);

// File: tb/pulse_seq_tx_tb.sv
module pulse_seq_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int LOOP_W = 10;
  localparam int ENT_W  = 9;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1, start = 1'b0, stop = 1'b0;
  logic cont_mode = 1'b0, loop_cnt_en = 1'b0, loop_cnt_clr = 1'b0;
  logic [LOOP_W-1:0] loop_limit = '0;
  logic [ENT_W-1:0]  entry_limit = '0;
  logic idle_level = 1'b0, idle_oe = 1'b0;
  logic mem_rd;
  logic [ADDR_W-1:0] mem_addr;
  logic [15:0] mem_rdata;
  logic tx_out, tx_oe, busy, end_evt, thr_evt, loop_evt;

  logic [15:0] mem [DEPTH];

  int total = 0;
  int bad = 0;
  int exp_q[$];
  int n_end = 0;
  logic lvl_log [0:511];
  logic oe_log  [0:511];
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

  pulse_seq_tx #(.ADDR_W(ADDR_W), .LOOP_W(LOOP_W), .ENT_W(ENT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start), .stop(stop),
    .cont_mode(cont_mode), .loop_cnt_en(loop_cnt_en), .loop_limit(loop_limit),
    .loop_cnt_clr(loop_cnt_clr), .entry_limit(entry_limit),
    .idle_level(idle_level), .idle_oe(idle_oe), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .tx_out(tx_out), .tx_oe(tx_oe),
    .busy(busy), .end_evt(end_evt), .thr_evt(thr_evt), .loop_evt(loop_evt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic push_addr(input int a);
    exp_q.push_back(a);
  endtask

  task automatic push_pass(input int n);
    for (int i = 0; i < n; i++) push_addr(i);
  endtask

  // scoreboard monitor: every read must match the next expected address
  always @(negedge clk) begin
    if (rst_n) begin
      if (end_evt) n_end++;
      if (mem_rd) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected read", int'(mem_addr), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(mem_addr) == e, "R4/R6 read order", int'(mem_addr), e);
        end
      end
    end
  end

  task automatic run_job(input int max_k, input int restart_at, input int clr_at,
                         output int end_k, output int thr_k, output int loop_k);
    end_k = -1; thr_k = -1; loop_k = -1;
    start = 1'b1;
    for (int k = 0; k < max_k; k++) begin
      @(negedge clk);
      start = (k == restart_at);
      loop_cnt_clr = (k == clr_at);
      lvl_log[k] = tx_out;
      oe_log[k]  = tx_oe;
      if (thr_evt && thr_k < 0) thr_k = k;
      if (loop_evt && loop_k < 0) loop_k = k;
      if (end_evt) begin
        end_k = k;
        break;
      end
    end
    start = 1'b0;
    loop_cnt_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int e_k, t_k, l_k, ends0;
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'h0000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 busy", busy, 0);
    chk(!mem_rd, "R1 mem_rd", mem_rd, 0);
    chk(!end_evt && !thr_evt && !loop_evt, "R1 events", end_evt, 0);

    // R11 idle drive
    idle_level = 1'b1; idle_oe = 1'b1;
    @(negedge clk);
    chk(tx_out == 1'b1 && tx_oe == 1'b1, "R11 idle drive", {tx_out, tx_oe}, 3);
    idle_level = 1'b0;

    // single pass: 1 for 3 ticks, 0 for 2 ticks, terminator
    mem[0] = 16'h8003; mem[1] = 16'h0002; mem[2] = 16'h0000;
    entry_limit = 9'd2;
    push_pass(3);
    run_job(100, 3, -1, e_k, t_k, l_k);
    chk(e_k == 11, "R5 one-shot end cycle", e_k, 11);
    chk(t_k == 9, "R9 threshold cycle", t_k, 9);
    chk(lvl_log[1] == 1'b0, "R3 pre-entry level", lvl_log[1], 0);
    chk(lvl_log[2] && lvl_log[4] && lvl_log[6], "R3 high entry", lvl_log[4], 1);
    chk(lvl_log[7] == 1'b0, "R3 low entry", lvl_log[7], 0);
    chk(oe_log[3] == 1'b1, "R3 oe active", oe_log[3], 1);
    chk(l_k == -1, "R7 no loop event in one-shot", l_k, -1);
    chk(exp_q.size() == 0, "R2 restart ignored, reads done", exp_q.size(), 0);
    @(negedge clk);
    chk(!end_evt && !busy, "R5 end pulse width", end_evt, 0);
    chk(tx_out == 1'b0 && tx_oe == 1'b1, "R11 after run", {tx_out, tx_oe}, 1);

    // counted repeat run, limit 3 passes, threshold on 5th entry
    cont_mode = 1'b1; loop_cnt_en = 1'b1; loop_limit = 10'd3; entry_limit = 9'd5;
    push_pass(3); push_pass(3); push_pass(3);
    run_job(200, -1, -1, e_k, t_k, l_k);
    chk(e_k == 33, "R7 counted end cycle", e_k, 33);
    chk(l_k == 33, "R7 loop event cycle", l_k, 33);
    chk(t_k == 27, "R9 threshold across passes", t_k, 27);
    chk(exp_q.size() == 0, "R6 restart reads", exp_q.size(), 0);
    @(negedge clk);

    // pass count cleared in the second pass, limit 2 -> three passes
    loop_limit = 10'd2; entry_limit = 9'd0;
    push_pass(3); push_pass(3); push_pass(3);
    run_job(200, -1, 15, e_k, t_k, l_k);
    chk(e_k == 33, "R8 clear extends run", e_k, 33);
    chk(l_k == 33, "R8 loop event after clear", l_k, 33);
    chk(t_k == -1, "R9 limit zero disables", t_k, -1);
    @(negedge clk);

    // unbounded repeat, then stop
    loop_cnt_en = 1'b0;
    push_pass(3); push_pass(3); push_addr(0);
    ends0 = n_end;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (24) @(negedge clk);
    chk(busy && tx_out, "R6 third pass playing", tx_out, 1);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(!busy, "R10 stop at tick", busy, 0);
    chk(tx_out == idle_level && tx_oe == idle_oe, "R10 idle output", tx_out, idle_level);
    chk(n_end == ends0, "R10 no end event", n_end, ends0);
    chk(exp_q.size() == 0, "R6 read count", exp_q.size(), 0);

    // tick gating and pending stop
    cont_mode = 1'b0;
    mem[0] = 16'h8003; mem[1] = 16'h0000;
    push_addr(0);
    tick_en = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    chk(busy && tx_out, "R12 hold without tick", tx_out, 1);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy, "R10 stop waits for tick", busy, 1);
    tick_en = 1'b1;
    @(negedge clk);
    chk(!busy, "R10 pending stop applied", busy, 0);
    chk(n_end == ends0, "R10 no end on stop", n_end, ends0);

    // full memory, ends at last address
    for (int i = 0; i < DEPTH; i++) mem[i] = {i[0], 15'd1};
    push_pass(DEPTH);
    run_job(300, -1, -1, e_k, t_k, l_k);
    chk(e_k == 3 * DEPTH, "R4 last-address end", e_k, 3 * DEPTH);
    chk(exp_q.size() == 0, "R4 all addresses read", exp_q.size(), 0);

    idle_level = 1'b1; idle_oe = 1'b0;
    @(negedge clk);
    chk(tx_out == 1'b1 && tx_oe == 1'b0, "R11 idle level high oe low", {tx_out, tx_oe}, 2);

    done_flag = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule